// File: doc/BRIEF.md
# Tone and Ringing Cadence Timer

This block sequences the on/off cadence of three signal generators: two tone channels and one ringing channel. Each channel has an "on" timer and an "off" timer. The two timers take turns while the channel runs. The block produces a gate for each generator, which the generator uses as its oscillator enable. Every time a timer runs out, the block emits a one-cycle transition pulse and can latch an interrupt. The oscillators themselves lie outside the block.

All timers count down on a shared tick. The tick is derived from the clock by a fixed divider, and the default divider gives 8 kHz from 8 MHz. With 16-bit reload values, one period can therefore last a little over 8 seconds.

A small register port sets up the block. Through it, software writes the reload values, the per-channel enables and the per-timer interrupt enables. It also clears latched interrupts by writing ones to them. The ringing channel adds one more condition. It runs only while a 3-bit line-state field holds the ringing code. When that code is removed, the ringing channel does not stop at once if an "on" burst is in progress: it finishes the burst before the line leaves the ringing state.

Top module: `cadence_timer`

## Requirements
- R1: After reset, every gate output, `ringingState`, `irq` and `edgePulse` are 0, and every register reads back as 0.
- R2: A channel whose control register has oscillator enable (bit 0), on-timer enable (bit 1) and off-timer enable (bit 2) set alternates between two phases. The gate stays high for (onReload+1) ticks and then low for (offReload+1) ticks, where one tick is TICK_DIV clock cycles.
- R3: When an on timer expires, `edgePulse` is high for one cycle on the even bit of its channel. When an off timer expires, the pulse appears on the odd bit. The bit order is: bit 0 tone-1 on, bit 1 tone-1 off, bit 2 tone-2 on, bit 3 tone-2 off, bit 4 ring on, bit 5 ring off. The pulse appears in the cycle before the gate changes.
- R4: Pending bit k (register 0x1, same bit order as R3) is set by transition k only when bit k of the interrupt enable register (0x0) is 1. `irq` is the OR of all pending bits.
- R5: Writing register 0x1 clears each pending bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. If a transition sets a bit in the same cycle as a write clears it, the bit ends up set.
- R6: With the off-timer enable at 0, the gate stays high continuously after the first on period ends, and no off transition occurs.
- R7: With the on-timer enable at 0, the gate stays high continuously once the oscillator is enabled, and no transitions occur.
- R8: Clearing the oscillator enable of a tone channel drops its gate by the second clock edge after the write. Setting the enable again starts a new on period.
- R9: The ringing channel runs only while its oscillator enable is 1 and the line-state field (register 0x2, bits 2:0) holds 3'b100. While it runs, `ringingState` is 1.
- R10: When the ringing condition is removed during an on period, the ring gate and `ringingState` stay high until that on period expires, and both fall after the edge of that expiry. When the condition is removed during an off period, `ringingState` falls by the second edge after the write.
- R11: Register map: 0x0 interrupt enable [5:0], 0x1 pending [5:0], 0x2 line state [2:0]. Tone-1 uses 0x4 control [2:0], 0x5 on reload and 0x6 off reload. Tone-2 uses 0x8/0x9/0xA, and the ring channel uses 0xC/0xD/0xE. Reads return the stored value with unused bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address (write and read) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr` (combinational) |
| toneGate | output | 2 | Oscillator enables of tone channels 1 and 2 |
| ringGate | output | 1 | Oscillator enable of the ringing generator |
| ringingState | output | 1 | Line is in the ringing state |
| edgePulse | output | 6 | One-cycle timer expiry pulses |
| irq | output | 1 | OR of the pending bits |

## Verification
The bench builds the block with TICK_DIV set to 4 and TIMER_W left at 16. With this setting a cadence period lasts only a few dozen clock cycles. The on and off lengths can then be measured exactly in cycles, after the first partial tick. The same setting makes a timer expiry predictable to the cycle, so a pending-bit clear can be placed on the very cycle of an expiry. It also lets the bench remove the ringing condition both in the middle of an on burst and in the middle of an off gap.

// File: rtl/cadence_pkg.sv
package cadence_pkg;
  localparam int NUM_CHAN = 3;
  localparam int RING_IDX = 2;
  localparam int NUM_EVT  = 2 * NUM_CHAN;
  localparam int ADDR_W   = 4;

  localparam logic [ADDR_W-1:0] ADDR_INTEN = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_PEND  = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_LINE  = 4'h2;
  localparam logic [2:0]        LINE_RINGING = 3'b100;

  typedef enum logic [1:0] {CH_IDLE, CH_ON, CH_OFF, CH_HOLD} chanState_t;

  typedef struct packed {
    logic inactEn;
    logic actEn;
    logic oscEn;
  } chanCfg_t;

  typedef struct packed {
    logic                tick;
    logic [NUM_CHAN-1:0] run;
    logic [NUM_CHAN-1:0] drainOnStop;
  } cadStrobe_t;
endpackage

// File: rtl/cadence_tick.sv
module cadence_tick #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] divCnt;

  assign tick = (divCnt == CW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // R2: ticks are isolated single-cycle strobes
  a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
endmodule

// File: rtl/cadence_regs.sv
module cadence_regs
  import cadence_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int DATA_W  = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrEn,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wrData,
  output logic [DATA_W-1:0]                  rdData,
  input  logic                               tick,
  input  logic [NUM_EVT-1:0]                 events,
  output cadStrobe_t                         strobe,
  output chanCfg_t [NUM_CHAN-1:0]            cfg,
  output logic [NUM_CHAN-1:0][TIMER_W-1:0]   actReload,
  output logic [NUM_CHAN-1:0][TIMER_W-1:0]   inactReload,
  output logic                               irq
);
  logic [NUM_EVT-1:0] intEn;
  logic [NUM_EVT-1:0] pending;
  logic [NUM_EVT-1:0] setVec;
  logic [NUM_EVT-1:0] pendClr;
  logic [2:0]         lineState;

  assign setVec  = events & intEn;
  assign pendClr = (wrEn && addr == ADDR_PEND) ? wrData[NUM_EVT-1:0] : '0;
  assign irq     = |pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn     <= '0;
      pending   <= '0;
      lineState <= '0;
    end else begin
      pending <= (pending & ~pendClr) | setVec;
      if (wrEn && addr == ADDR_INTEN) intEn     <= wrData[NUM_EVT-1:0];
      if (wrEn && addr == ADDR_LINE)  lineState <= wrData[2:0];
    end
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chanRegs
    localparam logic [1:0] SLOT = 2'(c + 1);
    chanCfg_t            cfgQ;
    logic [TIMER_W-1:0]  actQ;
    logic [TIMER_W-1:0]  inactQ;
    logic                hit;

    assign hit = wrEn && (addr[3:2] == SLOT);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ   <= '0;
        actQ   <= '0;
        inactQ <= '0;
      end else if (hit) begin
        case (addr[1:0])
          2'd0:    cfgQ   <= chanCfg_t'(wrData[2:0]);
          2'd1:    actQ   <= wrData[TIMER_W-1:0];
          2'd2:    inactQ <= wrData[TIMER_W-1:0];
          default: ;
        endcase
      end
    end

    assign cfg[c]         = cfgQ;
    assign actReload[c]   = actQ;
    assign inactReload[c] = inactQ;
  end

  always_comb begin
    strobe.tick = tick;
    for (int c = 0; c < NUM_CHAN; c++) begin
      strobe.run[c]         = cfg[c].oscEn &&
                              ((c != RING_IDX) || (lineState == LINE_RINGING));
      strobe.drainOnStop[c] = (c == RING_IDX);
    end
  end

  always_comb begin
    rdData = '0;
    if (addr[3:2] == 2'd0) begin
      case (addr[1:0])
        2'd0:    rdData[NUM_EVT-1:0] = intEn;
        2'd1:    rdData[NUM_EVT-1:0] = pending;
        2'd2:    rdData[2:0]         = lineState;
        default: ;
      endcase
    end else begin
      for (int c = 0; c < NUM_CHAN; c++) begin
        if (addr[3:2] == 2'(c + 1)) begin
          case (addr[1:0])
            2'd0:    rdData[2:0]         = cfg[c];
            2'd1:    rdData[TIMER_W-1:0] = actReload[c];
            2'd2:    rdData[TIMER_W-1:0] = inactReload[c];
            default: ;
          endcase
        end
      end
    end
  end

  // R4: a bit only rises when its enable was set
  a_r4_pend_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(intEn)) == '0));
  // R5: a hardware set always lands, even against a clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((pending & $past(setVec)) == $past(setVec)));
  // R5: a clear without a concurrent set empties the bit
  a_r5_clear_lands: assert property (@(posedge clk) disable iff (!rstN)
    (|pendClr) |=> ((pending & $past(pendClr & ~setVec)) == '0));
endmodule

// File: rtl/cadence_chan.sv
module cadence_chan
  import cadence_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               run,
  input  logic               drain,
  input  chanCfg_t           cfg,
  input  logic [TIMER_W-1:0] actReload,
  input  logic [TIMER_W-1:0] inactReload,
  output logic               gate,
  output logic               busy,
  output logic               actDone,
  output logic               inactDone
);
  chanState_t         state, stateNext;
  logic [TIMER_W-1:0] cnt, cntNext;
  logic               atZero;

  assign atZero = (cnt == '0);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    actDone   = 1'b0;
    inactDone = 1'b0;
    unique case (state)
      CH_IDLE: begin
        if (run) begin
          stateNext = cfg.actEn ? CH_ON : CH_HOLD;
          cntNext   = actReload;
        end
      end
      CH_ON: begin
        if (!run && !drain) begin
          stateNext = CH_IDLE;
        end else if (tick) begin
          if (atZero) begin
            actDone = 1'b1;
            if (!run) begin
              stateNext = CH_IDLE;
            end else if (cfg.inactEn) begin
              stateNext = CH_OFF;
              cntNext   = inactReload;
            end else begin
              stateNext = CH_HOLD;
            end
          end else begin
            cntNext = cnt - 1'b1;
          end
        end
      end
      CH_OFF: begin
        if (!run) begin
          stateNext = CH_IDLE;
        end else if (tick) begin
          if (atZero) begin
            inactDone = 1'b1;
            stateNext = CH_ON;
            cntNext   = actReload;
          end else begin
            cntNext = cnt - 1'b1;
          end
        end
      end
      CH_HOLD: begin
        if (!run) stateNext = CH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= CH_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign gate = (state == CH_ON) || (state == CH_HOLD);
  assign busy = (state != CH_IDLE);

  // R3: one transition at a time per channel
  a_r3_one_event: assert property (@(posedge clk) disable iff (!rstN)
    !(actDone && inactDone));
  // R3: transitions only on a tick
  a_r3_event_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (actDone || inactDone) |-> tick);
  // R6: a held channel keeps its gate while it runs
  a_r6_hold_keeps_gate: assert property (@(posedge clk) disable iff (!rstN)
    (state == CH_HOLD && run) |=> gate);
  // R8: a stopped non-draining channel drops its gate
  a_r8_stop_drops_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !drain) |=> !gate);
  // R10: a stop during the off phase ends at once
  a_r10_off_exit: assert property (@(posedge clk) disable iff (!rstN)
    (!run && state == CH_OFF) |=> !busy);
endmodule

// File: rtl/cadence_timer.sv
module cadence_timer
  import cadence_pkg::*;
#(
  parameter int TICK_DIV = 1000,
  parameter int TIMER_W  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic [1:0]  toneGate,
  output logic        ringGate,
  output logic        ringingState,
  output logic [5:0]  edgePulse,
  output logic        irq
);
  localparam int DATA_W = 16;

  logic                             tick;
  cadStrobe_t                       strobe;
  chanCfg_t [NUM_CHAN-1:0]          cfg;
  logic [NUM_CHAN-1:0][TIMER_W-1:0] actReload;
  logic [NUM_CHAN-1:0][TIMER_W-1:0] inactReload;
  logic [NUM_CHAN-1:0]              gateVec;
  logic [NUM_CHAN-1:0]              busyVec;
  logic [NUM_EVT-1:0]               events;

  cadence_tick #(.TICK_DIV(TICK_DIV)) uTick (
    .clk(clk), .rstN(rstN), .tick(tick)
  );

  cadence_regs #(.TIMER_W(TIMER_W), .DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tick(tick), .events(events), .strobe(strobe),
    .cfg(cfg), .actReload(actReload), .inactReload(inactReload), .irq(irq)
  );

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    cadence_chan #(.TIMER_W(TIMER_W)) uChan (
      .clk(clk), .rstN(rstN), .tick(strobe.tick), .run(strobe.run[c]),
      .drain(strobe.drainOnStop[c]), .cfg(cfg[c]),
      .actReload(actReload[c]), .inactReload(inactReload[c]),
      .gate(gateVec[c]), .busy(busyVec[c]),
      .actDone(events[2*c]), .inactDone(events[2*c+1])
    );
  end

  assign toneGate     = gateVec[1:0];
  assign ringGate     = gateVec[RING_IDX];
  assign ringingState = busyVec[RING_IDX];
  assign edgePulse    = events;
endmodule

// File: tb/cadence_timer_test.sv
module cadence_timer_test;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  toneGate;
  logic        ringGate;
  logic        ringingState;
  logic [5:0]  edgePulse;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cadence_timer #(.TICK_DIV(DIV), .TIMER_W(16)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .toneGate(toneGate), .ringGate(ringGate),
    .ringingState(ringingState), .edgePulse(edgePulse), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic waitPulse(input int bitIdx);
    do @(negedge clk); while (edgePulse[bitIdx] !== 1'b1);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 toneGate", 32'(toneGate), 0);
    check("R1 ringGate", 32'(ringGate), 0);
    check("R1 ringingState", 32'(ringingState), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 edgePulse", 32'(edgePulse), 0);
    for (int a = 0; a < 16; a++) begin
      readReg(4'(a), v);
      check($sformatf("R1 reg %0d", a), 32'(v), 0);
    end
  endtask

  task automatic t_readback();
    logic [15:0] v;
    writeReg(4'h0, 16'hFFFF); readReg(4'h0, v); check("R11 inten", 32'(v), 32'h3F);
    writeReg(4'h2, 16'h0005); readReg(4'h2, v); check("R11 line", 32'(v), 32'h5);
    writeReg(4'h9, 16'h1234); readReg(4'h9, v); check("R11 tone2 on", 32'(v), 32'h1234);
    writeReg(4'hE, 16'hBEEF); readReg(4'hE, v); check("R11 ring off", 32'(v), 32'hBEEF);
    writeReg(4'hC, 16'hFFF0); readReg(4'hC, v); check("R11 ring ctrl", 32'(v), 32'h0);
    readReg(4'h3, v); check("R11 hole", 32'(v), 0);
    writeReg(4'h0, 16'h0); writeReg(4'h2, 16'h0);
    writeReg(4'h9, 16'h0); writeReg(4'hE, 16'h0);
  endtask

  task automatic t_tone_cadence();
    int n;
    int cnt [6];
    writeReg(4'h5, 16'd2);
    writeReg(4'h6, 16'd1);
    writeReg(4'h4, 16'h7);
    do @(negedge clk); while (toneGate[0] !== 1'b1);
    do @(negedge clk); while (toneGate[0] !== 1'b0);
    n = 1;
    forever begin @(negedge clk); if (toneGate[0]) break; n++; end
    check("R2 off length", 32'(n), 32'(2 * DIV));
    n = 1;
    forever begin @(negedge clk); if (!toneGate[0]) break; n++; end
    check("R2 on length", 32'(n), 32'(3 * DIV));
    for (int i = 0; i < 6; i++) cnt[i] = 0;
    repeat (40) begin
      @(negedge clk);
      for (int i = 0; i < 6; i++) if (edgePulse[i]) cnt[i]++;
    end
    check("R3 tone1 on pulses", 32'(cnt[0]), 2);
    check("R3 tone1 off pulses", 32'(cnt[1]), 2);
    check("R3 other pulses", 32'(cnt[2] + cnt[3] + cnt[4] + cnt[5]), 0);
  endtask

  task automatic t_interrupts();
    logic [15:0] v;
    writeReg(4'h0, 16'h0001);
    writeReg(4'h1, 16'h003F);
    repeat (25) @(negedge clk);
    readReg(4'h1, v);
    check("R4 only enabled bit pending", 32'(v), 32'h1);
    check("R4 irq set", 32'(irq), 1);
    waitPulse(1);
    writeReg(4'h1, 16'h0001);
    readReg(4'h1, v);
    check("R5 clear", 32'(v), 0);
    check("R4 irq cleared", 32'(irq), 0);
    waitPulse(0);
    writeReg(4'h1, 16'h0000);
    readReg(4'h1, v);
    check("R5 zero write keeps", 32'(v), 32'h1);
    waitPulse(0);
    repeat (19) @(negedge clk);
    @(negedge clk);
    check("R3 pulse on predicted cycle", 32'(edgePulse[0]), 1);
    wrEn = 1'b1; addr = 4'h1; wrData = 16'h0001;
    @(negedge clk);
    wrEn = 1'b0;
    readReg(4'h1, v);
    check("R5 set beats clear", 32'(v), 32'h1);
  endtask

  task automatic t_stop_tone();
    int ev;
    writeReg(4'h4, 16'h0);
    @(negedge clk);
    check("R8 tone1 gate off", 32'(toneGate[0]), 0);
    ev = 0;
    repeat (30) begin @(negedge clk); if (edgePulse[1:0] != 0 || toneGate[0]) ev++; end
    check("R8 tone1 silent", 32'(ev), 0);
    writeReg(4'h1, 16'h003F);
    writeReg(4'h0, 16'h0);
  endtask

  task automatic t_no_inactive();
    int bad;
    writeReg(4'h9, 16'd1);
    writeReg(4'h8, 16'h3);
    waitPulse(2);
    bad = 0;
    repeat (30) begin @(negedge clk); if (!toneGate[1] || edgePulse[3]) bad++; end
    check("R6 stays on", 32'(bad), 0);
    writeReg(4'h8, 16'h0);
    @(negedge clk);
    check("R8 tone2 gate off", 32'(toneGate[1]), 0);
  endtask

  task automatic t_no_active();
    int bad;
    writeReg(4'h8, 16'h1);
    repeat (2) @(negedge clk);
    check("R8 restart gate on", 32'(toneGate[1]), 1);
    bad = 0;
    repeat (30) begin @(negedge clk); if (!toneGate[1] || edgePulse[3:2] != 0) bad++; end
    check("R7 continuous, no events", 32'(bad), 0);
    writeReg(4'h8, 16'h0);
  endtask

  task automatic t_ring();
    logic [15:0] v;
    writeReg(4'h0, 16'h0030);
    writeReg(4'hD, 16'd3);
    writeReg(4'hE, 16'd3);
    writeReg(4'h2, 16'h0004);
    repeat (3) @(negedge clk);
    check("R9 no ringing without osc enable", 32'(ringingState), 0);
    writeReg(4'h2, 16'h0003);
    writeReg(4'hC, 16'h7);
    repeat (3) @(negedge clk);
    check("R9 wrong code does not ring", 32'(ringingState), 0);
    writeReg(4'h2, 16'h0004);
    @(negedge clk);
    check("R9 ringing state", 32'(ringingState), 1);
    check("R9 ring gate", 32'(ringGate), 1);
    waitPulse(5);
    writeReg(4'h2, 16'h0000);
    repeat (8) @(negedge clk);
    check("R10 gate held through burst", 32'(ringGate), 1);
    check("R10 state held through burst", 32'(ringingState), 1);
    repeat (6) @(negedge clk);
    check("R10 burst ends on time", 32'(edgePulse[4]), 1);
    @(negedge clk);
    check("R10 gate after burst", 32'(ringGate), 0);
    check("R10 state after burst", 32'(ringingState), 0);
    writeReg(4'h2, 16'h0004);
    waitPulse(4);
    writeReg(4'h2, 16'h0000);
    @(negedge clk);
    check("R10 exit during off", 32'(ringingState), 0);
    readReg(4'h1, v);
    check("R4 ring pending bits", 32'(v), 32'h30);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_tone_cadence();
    t_interrupts();
    t_stop_tone();
    t_no_inactive();
    t_no_active();
    t_ring();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule